// File: doc/BRIEF.md
# Pulse-Space Infrared Symbol Decoder

This block turns a synchronised, demodulated infrared line into a received message of up to 64 bits. For every mark/space pair it counts the mark width and the whole symbol period (mark plus space) in clock cycles. It then matches the pair against a leader window and four data-symbol windows. Each matched data symbol adds one bit to a shift register. A long low gap on the line marks the end of the message. If the bit count at that point lies within programmed limits, the data and length are latched and a valid flag is raised.

Software drives the block through a small word-addressed register port. Through it, software sets the control flags, the timing windows and the end-of-message limits, and it reads back status and data. The mark that follows the last data symbol acts only as a terminator. Its rising edge closes the last symbol, and the pulse itself adds no bit.

Top module: `ir_symbol_decoder`

## Requirements
- R1: After reset the status word (address 7), both data words (addresses 8 and 9) and `msg_valid` read zero, and the decoder is disabled.
- R2: A timing word holds four byte fields: [31:24] period max, [23:16] period min, [15:8] width max and [7:0] width min. A data symbol matches when width lies in [wmin, wmax] cycles and period lies in [2·pmin, 2·pmax] cycles. The leader (address 1) uses 16-cycle units for both its width and period fields.
- R3: The data windows sit at addresses 2 to 5 and carry codes 00, 01, 10 and 11. Codes 00 and 10 yield bit 0, and codes 01 and 11 yield bit 1. A window whose width-max field is zero is disabled, and when several windows match, the lowest code wins.
- R4: Control bit 3 selects the bit order. When it is 0 the first received bit lands in data bit 0. When it is 1 the data shifts left, so the last received bit lands in bit 0.
- R5: Control bit 4 inverts every received bit, and control bit 2 inverts the line polarity, which makes a low level count as a mark.
- R6: With control bit 1 set, the first symbol of a message must match the leader window and contributes no bit. With it clear, the first symbol is already data.
- R7: A symbol that matches no enabled window aborts the message, and so does a 65th data bit. The decoder then waits for a fresh rising edge to start again, and a later well-formed message decodes normally.
- R8: A message ends once the line has stayed low for 8·gap cycles, where gap is bits [7:0] of address 6 and a value of 0 means never. The message is kept only if its bit count lies in [minlen, maxlen]; otherwise it is dropped and valid is left unchanged.
- R9: At address 6, minlen is bits [20:16] and is stored with bit 0 cleared, so its maximum is 30. Maxlen is bits [29:24]; it is stored with bit 0 cleared, and any value above 48 is stored as 48.
- R10: The status word has valid in bit 0 and the bit length in bits [14:8]. Address 8 returns data bits [31:0] and address 9 returns bits [63:32]. `msg_valid` follows the status valid bit.
- R11: Writing the status word with bit 0 clear acknowledges a message and clears valid. A new message that arrives while valid is still set replaces the data and length, and valid stays set.
- R12: Control bit 0 enables decoding. While it is 0 the line is ignored and no message is produced. Control bits [9:8] hold a code-type value that reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line, already synchronised to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| msg_valid | output | 1 | High while an unacknowledged message is held |

## Verification
A stuck or wrong receive state shows up at the ports only when a message ends. The symptom is a missing or unexpected valid flag, or a wrong length in the status word, in the cycle after the 8·gap idle count completes. A wrong symbol classification or a wrong bit position shows up as wrong data words at that same moment. This is why each scenario sends a whole message and then reads status and both data words after the gap. Abort and discard cases are checked by reading a clear status, followed by a good message that proves the decoder recovered.

// File: rtl/ir_dec_pkg.sv
// Shared types and helpers for the infrared symbol decoder.
// Assumes timing fields are 8 bits wide and the message is at most 64 bits.
package ir_dec_pkg;
    localparam int FLD_W    = 8;
    localparam int MSG_BITS = 64;
    localparam int N_SYM    = 4;
    localparam int LEN_W    = $clog2(MSG_BITS + 1);

    typedef struct packed {
        logic [FLD_W-1:0] per_max;
        logic [FLD_W-1:0] per_min;
        logic [FLD_W-1:0] wid_max;
        logic [FLD_W-1:0] wid_min;
    } win_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_DATA} rx_state_t;

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_LEAD = 4'd1;
    localparam logic [3:0] A_SYM0 = 4'd2;
    localparam logic [3:0] A_SYM1 = 4'd3;
    localparam logic [3:0] A_SYM2 = 4'd4;
    localparam logic [3:0] A_SYM3 = 4'd5;
    localparam logic [3:0] A_GAP  = 4'd6;
    localparam logic [3:0] A_STAT = 4'd7;
    localparam logic [3:0] A_DLO  = 4'd8;
    localparam logic [3:0] A_DHI  = 4'd9;

    // True when val lies inside [lo, hi] after both bounds are scaled by 2**sh.
    function automatic logic in_range(input logic [15:0] val,
                                      input logic [FLD_W-1:0] lo,
                                      input logic [FLD_W-1:0] hi,
                                      input int unsigned sh);
        logic [15:0] l;
        logic [15:0] h;
        l = 16'(lo) << sh;
        h = 16'(hi) << sh;
        return (val >= l) && (val <= h);
    endfunction
endpackage

// File: rtl/ir_edge_timer.sv
// Applies polarity, finds rising edges of the mark level and measures
// mark width, symbol period and current space length in clock cycles.
// Assumes ir_in is already synchronous to clk. Counters saturate.
module ir_edge_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_in,
    input  logic             pol_inv,
    output logic             lvl,
    output logic             rise,
    output logic [CNT_W-1:0] wid,
    output logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] spc
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    logic lvl_q;

    assign lvl  = ir_in ^ pol_inv;
    assign rise = lvl & ~lvl_q;

    // Remember the previous mark level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // Restart the counters at each rising edge, then count width, period and space.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wid <= '0;
            per <= '0;
            spc <= '0;
        end else if (rise) begin
            wid <= CNT_W'(1);
            per <= CNT_W'(1);
            spc <= '0;
        end else begin
            if (per != CMAX)         per <= per + 1'b1;
            if (lvl && wid != CMAX)  wid <= wid + 1'b1;
            if (!lvl && spc != CMAX) spc <= spc + 1'b1;
        end
    end
endmodule

// File: rtl/ir_symbol_classifier.sv
// Matches a measured width/period pair against the leader window (16-cycle
// units) and the data windows (period in 2-cycle units, width in cycles).
// A window with a zero width maximum is disabled; the lowest code wins.
module ir_symbol_classifier
    import ir_dec_pkg::*;
#(
    parameter int CNT_W = 14,
    localparam int CODE_W = $clog2(N_SYM)
) (
    input  logic                    [CNT_W-1:0] wid,
    input  logic                    [CNT_W-1:0] per,
    input  win_t                                lead_win,
    input  win_t   [N_SYM-1:0]                  sym_win,
    output logic                                lead_hit,
    output logic                                sym_hit,
    output logic                   [CODE_W-1:0] sym_code
);
    logic [N_SYM-1:0] match;

    assign lead_hit = (lead_win.wid_max != '0)
                   && in_range(16'(wid), lead_win.wid_min, lead_win.wid_max, 4)
                   && in_range(16'(per), lead_win.per_min, lead_win.per_max, 4);

    for (genvar i = 0; i < N_SYM; i++) begin : g_win
        assign match[i] = (sym_win[i].wid_max != '0)
                       && in_range(16'(wid), sym_win[i].wid_min, sym_win[i].wid_max, 0)
                       && in_range(16'(per), sym_win[i].per_min, sym_win[i].per_max, 1);
    end

    assign sym_hit = |match;

    // Pick the lowest matching code.
    always_comb begin
        sym_code = '0;
        for (int i = N_SYM - 1; i >= 0; i--) begin
            if (match[i]) sym_code = CODE_W'(i);
        end
    end
endmodule

// File: rtl/ir_frame_assembler.sv
// Receive state machine: waits for a first edge, optionally checks the
// leader, shifts in data bits and closes the message on the idle gap.
// Assumes classifier results are valid in the cycle of each rising edge.
module ir_frame_assembler
    import ir_dec_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                lead_en,
    input  logic                msb_first,
    input  logic                bit_inv,
    input  logic                rise,
    input  logic                lvl,
    input  logic [CNT_W-1:0]    spc,
    input  logic [7:0]          gap_thr,
    input  logic [4:0]          min_len,
    input  logic [5:0]          max_len,
    input  logic                lead_hit,
    input  logic                sym_hit,
    input  logic                sym_bit,
    output logic                done,
    output logic [MSG_BITS-1:0] data_out,
    output logic [LEN_W-1:0]    len_out
);
    localparam int IDX_W = $clog2(MSG_BITS);

    rx_state_t             st;
    logic [LEN_W-1:0]      cnt;
    logic [MSG_BITS-1:0]   shreg;
    logic                  gap_hit;
    logic                  nbit;
    logic                  len_ok;

    assign gap_hit = !lvl && (gap_thr != '0) && (16'(spc) >= 16'({gap_thr, 3'b000}));
    assign nbit    = sym_bit ^ bit_inv;
    assign len_ok  = (cnt >= LEN_W'(min_len)) && (cnt <= LEN_W'(max_len));

    // Step the receive state, collect bits and latch a finished message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            done     <= 1'b0;
            data_out <= '0;
            len_out  <= '0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                st <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: if (rise) begin
                        st    <= lead_en ? ST_LEAD : ST_DATA;
                        cnt   <= '0;
                        shreg <= '0;
                    end
                    ST_LEAD: begin
                        if (rise)         st <= lead_hit ? ST_DATA : ST_IDLE;
                        else if (gap_hit) st <= ST_IDLE;
                    end
                    ST_DATA: begin
                        if (rise) begin
                            if (!sym_hit || cnt == LEN_W'(MSG_BITS)) begin
                                st <= ST_IDLE;
                            end else begin
                                cnt <= cnt + 1'b1;
                                if (msb_first) shreg <= {shreg[MSG_BITS-2:0], nbit};
                                else           shreg[cnt[IDX_W-1:0]] <= nbit;
                            end
                        end else if (gap_hit) begin
                            st <= ST_IDLE;
                            if (len_ok) begin
                                done     <= 1'b1;
                                data_out <= shreg;
                                len_out  <= cnt;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R12: a cleared enable parks the receiver.
    assert_disable_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> st == ST_IDLE);

    // R7: the bit count never passes the message capacity.
    assert_count_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_DATA |-> cnt <= LEN_W'(MSG_BITS));

    // R8: a latched message never carries more bits than the maximum in force.
    assert_len_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> len_out <= LEN_W'($past(max_len)));
endmodule

// File: rtl/ir_symbol_decoder.sv
// Top level: register file, valid/acknowledge handling and wiring of the
// edge timer, symbol classifier and frame assembler.
// Assumes a single-cycle write strobe and a combinational read port.
module ir_symbol_decoder
    import ir_dec_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_in,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        msg_valid
);
    logic [9:0]             ctrl_q;
    win_t                   lead_q;
    win_t [N_SYM-1:0]       sym_q;
    logic [7:0]             gap_thr;
    logic [4:0]             min_len;
    logic [5:0]             max_len;
    logic                   valid_q;
    logic [1:0]             sym_idx;
    logic                   lvl, rise, lead_hit, sym_hit, done;
    logic [CNT_W-1:0]       wid, per, spc;
    logic [1:0]             sym_code;
    logic [MSG_BITS-1:0]    data;
    logic [LEN_W-1:0]       len;
    logic                   ack;

    assign sym_idx   = 2'(reg_addr - A_SYM0);
    assign ack       = reg_wr && (reg_addr == A_STAT) && !reg_wdata[0];
    assign msg_valid = valid_q;

    // Configuration register writes, with length fields forced even.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            lead_q  <= '0;
            sym_q   <= '0;
            gap_thr <= '0;
            min_len <= '0;
            max_len <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: ctrl_q <= reg_wdata[9:0] & 10'h31F;
                A_LEAD: lead_q <= win_t'(reg_wdata);
                A_SYM0, A_SYM1, A_SYM2, A_SYM3: sym_q[sym_idx] <= win_t'(reg_wdata);
                A_GAP: begin
                    gap_thr <= reg_wdata[7:0];
                    min_len <= {reg_wdata[20:17], 1'b0};
                    max_len <= (reg_wdata[29:24] > 6'd48) ? 6'd48 : {reg_wdata[29:25], 1'b0};
                end
                default: ;
            endcase
        end
    end

    // Valid flag: set by a finished message, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    valid_q <= 1'b0;
        else if (done) valid_q <= 1'b1;
        else if (ack)  valid_q <= 1'b0;
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata[9:0] = ctrl_q;
            A_LEAD: reg_rdata = lead_q;
            A_SYM0, A_SYM1, A_SYM2, A_SYM3: reg_rdata = sym_q[sym_idx];
            A_GAP: begin
                reg_rdata[7:0]   = gap_thr;
                reg_rdata[20:16] = min_len;
                reg_rdata[29:24] = max_len;
            end
            A_STAT: begin
                reg_rdata[0]          = valid_q;
                reg_rdata[8 +: LEN_W] = len;
            end
            A_DLO: reg_rdata = data[31:0];
            A_DHI: reg_rdata = data[63:32];
            default: ;
        endcase
    end

    ir_edge_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .pol_inv(ctrl_q[2]),
        .lvl(lvl), .rise(rise), .wid(wid), .per(per), .spc(spc)
    );

    ir_symbol_classifier #(.CNT_W(CNT_W)) u_class (
        .wid(wid), .per(per), .lead_win(lead_q), .sym_win(sym_q),
        .lead_hit(lead_hit), .sym_hit(sym_hit), .sym_code(sym_code)
    );

    ir_frame_assembler #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .enable(ctrl_q[0]), .lead_en(ctrl_q[1]),
        .msb_first(ctrl_q[3]), .bit_inv(ctrl_q[4]), .rise(rise), .lvl(lvl),
        .spc(spc), .gap_thr(gap_thr), .min_len(min_len), .max_len(max_len),
        .lead_hit(lead_hit), .sym_hit(sym_hit), .sym_bit(sym_code[0]),
        .done(done), .data_out(data), .len_out(len)
    );

    // R10: valid only rises after the assembler finishes a message.
    assert_valid_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(done));

    // R11: an acknowledge with no new message clears valid.
    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !done) |=> !valid_q);

    // R11: a message arriving while valid keeps valid set.
    assert_overwrite_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && done) |=> valid_q);
endmodule

// File: tb/ir_symbol_decoder_test.sv
// Directed bench: one task per scenario, each checking its own results.
module ir_symbol_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] C_EN = 32'h01, C_LD = 32'h02, C_POL = 32'h04,
                            C_MSB = 32'h08, C_INV = 32'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid;
    logic        act = 1'b1;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;

    ir_symbol_decoder uut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] actual, input logic [63:0] exp);
        checks++;
        if (actual !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, actual, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse(input int w, input int s);
        ir_in = act;
        repeat (w) @(negedge clk);
        ir_in = ~act;
        repeat (s) @(negedge clk);
    endtask

    // Sends an optional leader, n narrow data symbols and a terminator pulse.
    task automatic frame(input bit lead, input int n, input logic [63:0] bits);
        @(negedge clk);
        if (lead) pulse(32, 32);
        for (int i = 0; i < n; i++) pulse(4, bits[i] ? 12 : 4);
        pulse(4, 60);
    endtask

    task automatic expect_msg(input string req, input int len, input logic [63:0] val);
        logic [31:0] v;
        rd(4'd7, v); chk({req, " status"}, 64'(v), 64'((len << 8) | 1));
        rd(4'd8, v); chk({req, " data low"}, 64'(v), val[31:0]);
        rd(4'd9, v); chk({req, " data high"}, 64'(v), val[63:32]);
        chk({req, " msg_valid"}, 64'(msg_valid), 64'd1);
        wr(4'd7, 32'h0);
    endtask

    task automatic expect_none(input string req);
        logic [31:0] v;
        rd(4'd7, v); chk({req, " no message"}, 64'(v[0]), 64'd0);
        chk({req, " msg_valid low"}, 64'(msg_valid), 64'd0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'd7, v); chk("R1 status after reset", 64'(v), 64'd0);
        rd(4'd8, v); chk("R1 data low after reset", 64'(v), 64'd0);
        rd(4'd9, v); chk("R1 data high after reset", 64'(v), 64'd0);
        chk("R1 msg_valid after reset", 64'(msg_valid), 64'd0);
    endtask

    task automatic t_config;
        logic [31:0] v;
        wr(4'd1, 32'h05030301);
        wr(4'd2, 32'h05030503);
        wr(4'd3, 32'h09070503);
        wr(4'd6, 32'h30000005);
        wr(4'd0, 32'h200 | C_EN | C_LD);
        rd(4'd0, v); chk("R12 control readback with code type", 64'(v), 64'h203);
    endtask

    task automatic t_lsb;
        frame(1, 8, 64'h1E);
        expect_msg("R2 R4 R10 lsb-first", 8, 64'h1E);
        chk("R11 valid cleared by ack", 64'(msg_valid), 64'd0);
    endtask

    task automatic t_msb;
        wr(4'd0, C_EN | C_LD | C_MSB);
        frame(1, 8, 64'h1E);
        expect_msg("R4 msb-first", 8, 64'h78);
    endtask

    task automatic t_inv;
        wr(4'd0, C_EN | C_LD | C_INV);
        frame(1, 8, 64'h1E);
        expect_msg("R5 bit invert", 8, 64'hE1);
    endtask

    task automatic t_pol;
        wr(4'd0, 32'h0);
        @(negedge clk); ir_in = 1'b1;
        wr(4'd0, C_EN | C_LD | C_POL);
        repeat (50) @(negedge clk);
        act = 1'b0;
        frame(1, 8, 64'h1E);
        expect_msg("R5 polarity invert", 8, 64'h1E);
        wr(4'd0, 32'h0);
        act = 1'b1;
        @(negedge clk); ir_in = 1'b0;
        repeat (50) @(negedge clk);
    endtask

    task automatic t_leader;
        wr(4'd0, C_EN);
        frame(0, 8, 64'h1E);
        expect_msg("R6 no leader mode", 8, 64'h1E);
        wr(4'd0, C_EN | C_LD);
        frame(0, 8, 64'h1E);
        expect_none("R6 leader missing");
    endtask

    task automatic t_abort;
        @(negedge clk);
        pulse(32, 32);
        for (int i = 0; i < 4; i++) pulse(4, 4);
        pulse(9, 4);
        for (int i = 0; i < 3; i++) pulse(4, 12);
        pulse(4, 60);
        expect_none("R7 bad symbol aborts");
        frame(1, 8, 64'h5A);
        expect_msg("R7 recovery after abort", 8, 64'h5A);
    endtask

    task automatic t_limits;
        wr(4'd6, 32'h300A0005);
        frame(1, 8, 64'h1E);
        expect_none("R8 below minimum length");
        wr(4'd6, 32'h06000005);
        frame(1, 8, 64'h1E);
        expect_none("R8 above maximum length");
        wr(4'd6, 32'h30000005);
    endtask

    task automatic t_round;
        logic [31:0] v;
        wr(4'd6, 32'h37070005);
        rd(4'd6, v); chk("R9 length fields rounded and saturated", 64'(v), 64'h30060005);
        wr(4'd6, 32'h0D000005);
        rd(4'd6, v); chk("R9 odd maximum rounded down", 64'(v), 64'h0C000005);
        wr(4'd6, 32'h30000005);
    endtask

    task automatic t_long;
        frame(1, 40, 64'h000000C35A960F1E);
        expect_msg("R10 forty bit message", 40, 64'h000000C35A960F1E);
    endtask

    task automatic t_overwrite;
        logic [31:0] v;
        frame(1, 8, 64'h1E);
        frame(1, 8, 64'h81);
        rd(4'd7, v); chk("R11 overwrite keeps valid", 64'(v), 64'h0801);
        rd(4'd8, v); chk("R11 overwrite replaces data", 64'(v), 64'h81);
        wr(4'd7, 32'h0);
        rd(4'd7, v); chk("R11 ack after overwrite", 64'(v[0]), 64'd0);
    endtask

    task automatic t_wide;
        wr(4'd4, 32'h05030907);
        wr(4'd5, 32'h09070907);
        @(negedge clk);
        pulse(32, 32);
        pulse(8, 8);
        pulse(8, 2);
        pulse(4, 12);
        pulse(8, 8);
        pulse(4, 60);
        expect_msg("R3 codes 10 and 11", 4, 64'hD);
    endtask

    task automatic t_disable;
        wr(4'd0, 32'h0);
        frame(1, 8, 64'h1E);
        expect_none("R12 disabled decoder");
        wr(4'd0, C_EN | C_LD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_config;
        t_lsb;
        t_msb;
        t_inv;
        t_pol;
        wr(4'd0, C_EN | C_LD);
        t_leader;
        t_abort;
        t_limits;
        t_round;
        t_long;
        t_overwrite;
        t_wide;
        t_disable;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule